// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets a host manage Ethernet PHYs over a two-wire MDIO bus using Clause 22 frames. The host writes one 32-bit command word. That word carries the PHY address, the register number, a read/write selector and, for a write, the 16-bit value. The block accepts the command, marks itself busy and shifts a complete 64-bit management frame out on MDC and MDIO. When the frame ends, busy drops. A read leaves the returned data, and a flag saying whether it is trustworthy, in the same word.

Each frame has 32 preamble ones, then the start pattern 01, then the opcode. After the opcode come the PHY address, the register number, two turnaround bits and 16 data bits, each field sent most significant bit first. MDC is the system clock divided by `2*DIV_HALF` and stays low between frames. The master changes MDIO while MDC is low, and it samples the PHY on the rising edge of MDC. At the end of every frame a completion flag is set in a cause register. That flag, gated by a mask register, drives an interrupt line. The host clears the flag by writing zero to its bit.

Top module: `mdio_c22_master`

## Requirements
- R1: After reset, the words at offsets 0x00, 0x7C and 0x80 all read 0, and `irq`, `mdc` and `mdio_oe` are low.
- R2: A write to offset 0x00 while idle starts a transaction. The word holds data in bits 15:0, the PHY address in bits 20:16 and the register number in bits 25:21, and bit 26 = 1 selects a read. Busy (bit 28) is high from the cycle after the write for exactly `128*DIV_HALF` cycles.
- R3: The serial bit order is 32 ones, then 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the PHY address and the register number MSB first. A write continues with turnaround 1,0 and the data MSB first. `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R4: `mdc` is low for `DIV_HALF` cycles and then high for `DIV_HALF` cycles in each of the 64 bit periods, and it stays low whenever the block is not busy.
- R5: On a read, `mdio_oe` goes low for frame bits 46 to 63 (turnaround and data). The data is sampled from `mdio_i` at the rising edges of `mdc`, and when the frame ends it appears MSB first in bits 15:0 of the word at 0x00.
- R6: The read-valid bit (bit 27) is set at the end of a read only if `mdio_i` was 0 at the rising `mdc` edge of the second turnaround bit. Any accepted command, including a write, clears it.
- R7: A command written to offset 0x00 while busy is ignored. The command fields and the frame in progress do not change.
- R8: Bit 4 of the cause word at 0x7C is set at the end of every transaction. Writing 0 to that bit clears it and writing 1 leaves it set. If completion and a clear fall in the same cycle, completion wins.
- R9: Bit 4 of the mask word at 0x80 is read/write, and `irq` is high exactly when the cause bit and the mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (pad driver) |
| mdio_i | input | 1 | MDIO value seen at the pad |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check the following on every cycle:
- busy follows an accepted command, and MDC is low while idle;
- the MDIO driver holds its value and its enable while MDC is high;
- read-valid is clear when a frame starts, and the command fields stay fixed while busy;
- the cause bit is set when busy falls, and `irq` is never high without a cause.

The rest needs the bench's scenarios and its per-cycle reference model:
- the exact serial bit order and the MDC period;
- the placement of the turnaround release and the sampled read data;
- read-valid staying clear after a bad turnaround;
- the write-zero-to-clear behaviour of the cause register.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // register offsets (byte addresses)
   localparam int unsigned OFS_CMD   = 'h00;
   localparam int unsigned OFS_CAUSE = 'h7C;
   localparam int unsigned OFS_MASK  = 'h80;
   // command/status word bit positions
   localparam int unsigned B_OP      = 26;
   localparam int unsigned B_RVALID  = 27;
   localparam int unsigned B_BUSY    = 28;
   // completion bit in cause and mask words
   localparam int unsigned B_DONE    = 4;
   // frame geometry
   localparam int unsigned FRAME_BITS = 64;
   localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
   localparam int unsigned TA_FIRST   = 46;
   localparam int unsigned TA_LAST    = 47;
   localparam int unsigned DATA_FIRST = 48;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int unsigned DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV_HALF == 1) begin : g_bypass
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV_HALF);
         logic [CW-1:0] cnt_q;
         assign tick = run && (cnt_q == CW'(DIV_HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q <= '0;
            else if (!run||tick) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        is_read,
   input  logic [4:0]  phy,
   input  logic [4:0]  regad,
   input  logic [15:0] wdata,
   input  logic        tick,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        ta_ok
);
   logic [FRAME_BITS-1:0] sh_q;
   logic [IDX_W-1:0]      idx_q;
   logic                  half_q, busy_q, rd_q, ta_q;
   logic [15:0]           rsh_q;
   logic                  last_bit;

   assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));
   assign done     = busy_q && tick && half_q && last_bit;
   assign busy     = busy_q;
   assign mdc      = half_q;
   assign mdio_o   = sh_q[FRAME_BITS-1];
   assign mdio_oe  = busy_q && !(rd_q && idx_q >= IDX_W'(TA_FIRST));
   assign rd_data  = rsh_q;
   assign ta_ok    = ta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0; idx_q <= '0; half_q <= 1'b0; busy_q <= 1'b0;
         rd_q <= 1'b0; ta_q <= 1'b0; rsh_q <= '0;
      end else if (start && !busy_q) begin
         sh_q   <= {32'hFFFF_FFFF, 2'b01, is_read ? 2'b10 : 2'b01, phy, regad,
                    is_read ? 2'b11 : 2'b10, is_read ? 16'hFFFF : wdata};
         idx_q  <= '0;
         half_q <= 1'b0;
         busy_q <= 1'b1;
         rd_q   <= is_read;
         ta_q   <= 1'b0;
      end else if (busy_q && tick) begin
         if (!half_q) begin
            half_q <= 1'b1;
            if (rd_q && idx_q == IDX_W'(TA_LAST))     ta_q  <= !mdio_i;
            if (rd_q && idx_q >= IDX_W'(DATA_FIRST))  rsh_q <= {rsh_q[14:0], mdio_i};
         end else begin
            half_q <= 1'b0;
            sh_q   <= sh_q << 1;
            if (last_bit) busy_q <= 1'b0;
            else          idx_q  <= idx_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
   import mdio_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              busy,
   input  logic              done,
   input  logic [15:0]       rd_data,
   input  logic              ta_ok,
   output logic              start,
   output logic [31:0]       rdata,
   output logic [31:0]       stat,
   output logic              cause,
   output logic              irq
);
   logic [15:0] dat_q;
   logic [4:0]  phy_q, reg_q;
   logic        op_q, rv_q, cause_q, mask_q;
   logic        hit_cmd, hit_cause, hit_mask;

   assign hit_cmd   = (addr == ADDR_W'(OFS_CMD));
   assign hit_cause = (addr == ADDR_W'(OFS_CAUSE));
   assign hit_mask  = (addr == ADDR_W'(OFS_MASK));
   assign start     = we && hit_cmd && !busy;
   assign stat      = {3'b000, busy, rv_q, op_q, reg_q, phy_q, dat_q};
   assign cause     = cause_q;
   assign irq       = cause_q && mask_q;

   always_comb begin
      rdata = '0;
      if (hit_cmd)        rdata = stat;
      else if (hit_cause) rdata[B_DONE] = cause_q;
      else if (hit_mask)  rdata[B_DONE] = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0; phy_q <= '0; reg_q <= '0;
         op_q <= 1'b0; rv_q <= 1'b0; cause_q <= 1'b0; mask_q <= 1'b0;
      end else begin
         if (start) begin
            dat_q <= wdata[15:0];
            phy_q <= wdata[20:16];
            reg_q <= wdata[25:21];
            op_q  <= wdata[B_OP];
            rv_q  <= 1'b0;
         end else if (done && op_q) begin
            dat_q <= rd_data;
            rv_q  <= ta_ok;
         end
         if (done)                                  cause_q <= 1'b1;
         else if (we && hit_cause && !wdata[B_DONE]) cause_q <= 1'b0;
         if (we && hit_mask) mask_q <= wdata[B_DONE];
      end
   end
endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master
   import mdio_pkg::*;
#(
   parameter int unsigned DIV_HALF = 2,
   parameter int unsigned ADDR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i,
   output logic              irq
);
   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8 to reach the mask offset");
      end
   endgenerate

   logic        start, tick, eng_busy, done, ta_ok, cause_w;
   logic [15:0] rd_data;
   logic [31:0] stat_word;

   mdio_csr #(.ADDR_W(ADDR_W)) u_csr (
      .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr), .wdata(csr_wdata),
      .busy(eng_busy), .done(done), .rd_data(rd_data), .ta_ok(ta_ok),
      .start(start), .rdata(csr_rdata), .stat(stat_word), .cause(cause_w), .irq(irq)
   );

   mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
      .clk(clk), .rst_n(rst_n), .run(eng_busy), .tick(tick)
   );

   mdio_frame_engine u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .is_read(csr_wdata[B_OP]),
      .phy(csr_wdata[20:16]), .regad(csr_wdata[25:21]), .wdata(csr_wdata[15:0]),
      .tick(tick), .mdio_i(mdio_i), .busy(eng_busy), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .done(done), .rd_data(rd_data), .ta_ok(ta_ok)
   );
endmodule

// File: rtl/mdio_c22_master_chk.sv
module mdio_c22_master_chk
   import mdio_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_we,
   input logic [ADDR_W-1:0] csr_addr,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic              irq,
   input logic              busy,
   input logic              cause,
   input logic [31:0]       stat
);
   logic cmd_wr;
   assign cmd_wr = csr_we && (csr_addr == ADDR_W'(OFS_CMD));

   a_r2_busy_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy) |=> busy);
   a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);
   a_r3_mdio_hold_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
   a_r6_rvalid_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !stat[B_RVALID]);
   a_r7_fields_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(stat[26:16]));
   a_r8_cause_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> cause);
   a_r9_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cause);
endmodule

bind mdio_c22_master mdio_c22_master_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
   .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq),
   .busy(eng_busy), .cause(cause_w), .stat(stat_word)
);

// File: tb/mdio_c22_master_tb_top.sv
`timescale 1ns/1ps
module mdio_c22_master_tb_top;
   localparam int D = 2;
   localparam int FRAME_CYC = 128 * D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [7:0]  csr_addr = 8'h00;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        mdc, mdio_o, mdio_oe, irq;
   logic        mdio_i = 1'b1;

   always #2.5 clk = ~clk;

   mdio_c22_master #(.DIV_HALF(D), .ADDR_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          m_busy, m_read, m_rv, m_cause, m_mask;
   int          m_t;
   logic [4:0]  m_phy, m_reg;
   logic [15:0] m_dat;
   logic [15:0] phy_val = 16'h0000;
   bit          ta_good = 1'b1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 0; m_read <= 0; m_rv <= 0; m_cause <= 0; m_mask <= 0;
         m_t <= 0; m_phy <= '0; m_reg <= '0; m_dat <= '0;
      end else begin
         if (csr_we && csr_addr == 8'h7C && !csr_wdata[4]) m_cause <= 0;
         if (csr_we && csr_addr == 8'h80) m_mask <= csr_wdata[4];
         if (m_busy) begin
            if (m_t == FRAME_CYC - 1) begin
               m_busy  <= 0;
               m_cause <= 1;
               if (m_read) begin m_dat <= phy_val; m_rv <= ta_good; end
            end else m_t <= m_t + 1;
         end else if (csr_we && csr_addr == 8'h00) begin
            m_busy <= 1; m_t <= 0;
            m_read <= csr_wdata[26];
            m_reg  <= csr_wdata[25:21];
            m_phy  <= csr_wdata[20:16];
            m_dat  <= csr_wdata[15:0];
            m_rv   <= 0;
         end
      end
   end

   function automatic bit exp_bit(int i);
      if (i < 32)  return 1'b1;
      if (i == 32) return 1'b0;
      if (i == 33) return 1'b1;
      if (i == 34) return m_read;
      if (i == 35) return !m_read;
      if (i <= 40) return m_phy[40 - i];
      if (i <= 45) return m_reg[45 - i];
      if (i == 46) return 1'b1;
      if (i == 47) return 1'b0;
      return m_dat[63 - i];
   endfunction

   // PHY model plus per-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         int idx;
         bit exp_mdc, exp_oe;
         idx = m_t / (2 * D);
         if (m_busy && m_read && idx == 47)      mdio_i = !ta_good;
         else if (m_busy && m_read && idx >= 48) mdio_i = phy_val[63 - idx];
         else                                    mdio_i = 1'b1;
         exp_mdc = m_busy && ((m_t / D) % 2 == 1);
         exp_oe  = m_busy && !(m_read && idx >= 46);
         chk(mdc == exp_mdc, "R4 mdc", {31'b0, mdc}, {31'b0, exp_mdc});
         chk(mdio_oe == exp_oe, "R5 mdio_oe", {31'b0, mdio_oe}, {31'b0, exp_oe});
         if (exp_oe)
            chk(mdio_o == exp_bit(idx), "R3 mdio_o", {31'b0, mdio_o}, {31'b0, exp_bit(idx)});
         chk(irq == (m_cause && m_mask), "R9 irq", {31'b0, irq}, {31'b0, m_cause && m_mask});
         if (csr_addr == 8'h00)
            chk(csr_rdata == {3'b000, m_busy, m_rv, m_read, m_reg, m_phy, m_dat},
                "R2 status word", csr_rdata, {3'b000, m_busy, m_rv, m_read, m_reg, m_phy, m_dat});
      end
   end

   // ---------------- host tasks ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(posedge clk); #1;
      csr_we = 1'b0; csr_addr = 8'h00; csr_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      csr_addr = a; #1;
      d = csr_rdata;
      csr_addr = 8'h00;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (csr_rdata[28]) @(negedge clk);
   endtask

   function automatic logic [31:0] mk(bit rd_op, logic [4:0] p, logic [4:0] r, logic [15:0] d);
      return {5'b0, rd_op, r, p, d};
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, v); chk(v == 0, "R1 cmd word after reset", v, 0);
      rd(8'h7C, v); chk(v == 0, "R1 cause after reset", v, 0);
      rd(8'h80, v); chk(v == 0, "R1 mask after reset", v, 0);
      chk({irq, mdc, mdio_oe} == 3'b000, "R1 outputs after reset", {29'b0, irq, mdc, mdio_oe}, 0);

      // R2/R3 write frame, R7 command while busy ignored
      wr(8'h00, mk(0, 5'h05, 5'h1A, 16'hA5C3));
      rd(8'h00, v); chk(v[28] == 1'b1, "R2 busy after command", v, 32'h1000_0000);
      repeat (20) @(posedge clk);
      wr(8'h00, mk(1, 5'h1F, 5'h03, 16'h1234));
      rd(8'h00, v); chk(v[26:16] == {1'b0, 5'h1A, 5'h05}, "R7 fields unchanged while busy",
                        {21'b0, v[26:16]}, {21'b0, 1'b0, 5'h1A, 5'h05});
      wait_idle();

      // R8/R9 cause and mask behaviour
      rd(8'h7C, v); chk(v == 32'h10, "R8 cause set after write frame", v, 32'h10);
      chk(irq == 1'b0, "R9 irq masked", {31'b0, irq}, 0);
      wr(8'h80, 32'h10);
      @(negedge clk); chk(irq == 1'b1, "R9 irq unmasked", {31'b0, irq}, 1);
      wr(8'h7C, 32'hFFFF_FFFF);
      rd(8'h7C, v); chk(v == 32'h10, "R8 writing one keeps cause", v, 32'h10);
      wr(8'h7C, 32'hFFFF_FFEF);
      rd(8'h7C, v); chk(v == 32'h0, "R8 writing zero clears cause", v, 0);
      @(negedge clk); chk(irq == 1'b0, "R9 irq after clear", {31'b0, irq}, 0);

      // R5/R6 read with proper turnaround
      phy_val = 16'h3C96; ta_good = 1'b1;
      wr(8'h00, mk(1, 5'h11, 5'h02, 16'h0000));
      wait_idle();
      rd(8'h00, v);
      chk(v[15:0] == 16'h3C96, "R5 read data", {16'b0, v[15:0]}, 32'h3C96);
      chk(v[27] == 1'b1, "R6 read-valid after good turnaround", {31'b0, v[27]}, 1);
      chk(irq == 1'b1, "R9 irq on read completion", {31'b0, irq}, 1);
      wr(8'h7C, 32'h0);

      // R6 read with missing turnaround
      phy_val = 16'h5A0F; ta_good = 1'b0;
      wr(8'h00, mk(1, 5'h00, 5'h1F, 16'h0000));
      wait_idle();
      rd(8'h00, v);
      chk(v[27] == 1'b0, "R6 read-valid clear after bad turnaround", {31'b0, v[27]}, 0);

      // R6 write command clears read-valid
      phy_val = 16'hFFFF; ta_good = 1'b1;
      wr(8'h00, mk(1, 5'h0A, 5'h15, 16'h0000));
      wait_idle();
      rd(8'h00, v); chk(v[27] == 1'b1, "R6 read-valid set before write", {31'b0, v[27]}, 1);
      wr(8'h00, mk(0, 5'h0A, 5'h15, 16'h0001));
      rd(8'h00, v); chk(v[27] == 1'b0, "R6 write clears read-valid", {31'b0, v[27]}, 0);
      wait_idle();
      rd(8'h7C, v); chk(v == 32'h10, "R8 cause after every frame", v, 32'h10);

      repeat (4) @(posedge clk);
      finish_run();
   end
endmodule